// File: doc/BRIEF.md
# Bus Glue Address Decoder for a 16-bit Asynchronous CPU Bus

This block is the glue logic that sits between a 68000-style CPU and its memories and peripherals. It watches the word address, the address strobe, the two data strobes, the read/write line and the function-code lines. From these it selects one of four 64 KB banks. Bank 0 holds a boot ROM pair. Banks 1 and 2 each hold an SRAM pair. Bank 3 holds two slow 8-bit peripherals: a parallel I/O controller on the upper byte lane and a serial controller on the lower byte lane. The ROM sits at the bottom of the map, so the reset stack pointer and start vector come from it and the vector table never moves.

The block also drives the two cycle-termination lines. Peripheral cycles and interrupt-acknowledge cycles get the synchronous peripheral request, which makes the CPU autovector. Every other strobed cycle gets the memory acknowledge at once, with no wait states. All outputs are active low and registered on the CPU clock. Each one reflects the bus inputs sampled at the previous rising edge. The block has no streaming data path, so no pin uses valid/ready.

Top module: `bus_glue_decoder`

## Requirements
- R1: While `rst_n` is low, every output is high (deasserted).
- R2: Word address bits A17:A16 pick the bank: 0 for ROM, 1 for SRAM pair 1, 2 for SRAM pair 2, 3 for I/O. Bits A23:A18 have no effect, so the 256 KB map repeats across the whole address space.
- R3: In each memory bank, the upper-byte select follows `uds_n` and the lower-byte select follows `lds_n`. When both strobes are low, both selects assert.
- R4: The ROM selects assert only when `rw` is 1 (read). A write to bank 0 asserts neither ROM select.
- R5: The SRAM selects assert for reads (`rw`=1) and for writes (`rw`=0).
- R6: `pio_cs_n` asserts in bank 3 when `uds_n` is low and the word offset A15:A1 is below 16. This covers byte addresses 0x30000 to 0x3001E, even bytes only.
- R7: `sio_cs_n` asserts in bank 3 when `lds_n` is low and the word offset A15:A1 is below 2. This covers byte addresses 0x30001 and 0x30003.
- R8: An interrupt-acknowledge cycle has `as_n` low with `fc[1]` and `fc[0]` both 1; `fc[2]` is not decoded. Such a cycle asserts `vpa_n` and asserts no chip select. `vpa_n` also asserts for every strobed bank-3 access.
- R9: While `as_n` is low, `dtack_n` is the exact complement of `vpa_n`. The two are never low together.
- R10: A cycle with `as_n` high deasserts every chip select, `dtack_n` and `vpa_n`.
- R11: Every output changes only at a rising clock edge. It shows the decode of the inputs sampled at that edge, so there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all outputs register on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 23 | Word address A23:A1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code lines |
| rom_hi_cs_n | output | 1 | Boot ROM upper-byte select |
| rom_lo_cs_n | output | 1 | Boot ROM lower-byte select |
| ram1_hi_cs_n | output | 1 | SRAM pair 1 upper-byte select |
| ram1_lo_cs_n | output | 1 | SRAM pair 1 lower-byte select |
| ram2_hi_cs_n | output | 1 | SRAM pair 2 upper-byte select |
| ram2_lo_cs_n | output | 1 | SRAM pair 2 lower-byte select |
| pio_cs_n | output | 1 | Parallel I/O controller select (upper lane) |
| sio_cs_n | output | 1 | Serial controller select (lower lane) |
| dtack_n | output | 1 | Memory acknowledge, active low |
| vpa_n | output | 1 | Synchronous peripheral request, active low |

## Verification
The bench builds the decoder with its default parameters: a 24-bit address, banks split at A16, 16 parallel-controller registers and 2 serial-controller registers. With these values, the mirror bits A23:A18 can be set to patterns that must have no effect. The window edges sit at word offsets 15/16 and 1/2, right beside each other, so the first address past each window can be probed next to the last one inside it. Random cycles over all function codes, strobes and directions are then compared every clock against a behavioural model in the bench.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int NUM_BANKS = 4;
  localparam int NUM_MEM   = 3;

  typedef enum logic [1:0] {
    BANK_ROM  = 2'd0,
    BANK_RAM1 = 2'd1,
    BANK_RAM2 = 2'd2,
    BANK_IO   = 2'd3
  } bank_e;

  // memory banks that only answer reads
  localparam logic [NUM_MEM-1:0] READ_ONLY_MASK = 3'b001;
endpackage

// File: rtl/glue_bank_dec.sv
module glue_bank_dec
  import glue_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int BANK_LSB = 16
) (
  input  logic [ADDR_W-1:1]    addr_i,
  input  logic                 as_n,
  input  logic [2:0]           fc,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic                 iack
);
  bank_e sel;

  always_comb begin
    sel  = bank_e'(addr_i[BANK_LSB+1:BANK_LSB]);
    iack = !as_n && fc[1] && fc[0];
    bank_hit = '0;
    if (!as_n && !iack) bank_hit[sel] = 1'b1;
  end
endmodule

// File: rtl/glue_lane_sel.sv
module glue_lane_sel
  import glue_pkg::*;
#(
  parameter logic [NUM_MEM-1:0] RO_MASK = READ_ONLY_MASK
) (
  input  logic [NUM_MEM-1:0] mem_hit,
  input  logic               uds_n,
  input  logic               lds_n,
  input  logic               rw,
  output logic [NUM_MEM-1:0] hi_req,
  output logic [NUM_MEM-1:0] lo_req
);
  for (genvar b = 0; b < NUM_MEM; b++) begin : g_bank
    if (RO_MASK[b]) begin : g_ro
      assign hi_req[b] = mem_hit[b] && rw && !uds_n;
      assign lo_req[b] = mem_hit[b] && rw && !lds_n;
    end else begin : g_rw
      assign hi_req[b] = mem_hit[b] && !uds_n;
      assign lo_req[b] = mem_hit[b] && !lds_n;
    end
  end
endmodule

// File: rtl/glue_handshake.sv
module glue_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic io_hit,
  input  logic iack,
  output logic dtack_n,
  output logic vpa_n
);
  logic sync_req, run_q;

  assign sync_req = io_hit || iack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dtack_n <= 1'b1;
      vpa_n   <= 1'b1;
      run_q   <= 1'b0;
    end else begin
      vpa_n   <= !(!as_n && sync_req);
      dtack_n <= !(!as_n && !sync_req);
      run_q   <= 1'b1;
    end
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !vpa_n));

  a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !$past(as_n)) |-> (dtack_n != vpa_n));

  a_r8_iack_vpa: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(iack)) |-> !vpa_n);
endmodule

// File: rtl/bus_glue_decoder.sv
module bus_glue_decoder
  import glue_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BANK_LSB  = 16,
  parameter int PIO_REGS  = 16,
  parameter int SIO_REGS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rw,
  input  logic [2:0]        fc,
  output logic              rom_hi_cs_n,
  output logic              rom_lo_cs_n,
  output logic              ram1_hi_cs_n,
  output logic              ram1_lo_cs_n,
  output logic              ram2_hi_cs_n,
  output logic              ram2_lo_cs_n,
  output logic              pio_cs_n,
  output logic              sio_cs_n,
  output logic              dtack_n,
  output logic              vpa_n
);
  localparam int OFS_W = BANK_LSB - 1;

  logic [NUM_BANKS-1:0] bank_hit;
  logic                 iack;
  logic [NUM_MEM-1:0]   hi_req, lo_req;
  logic [OFS_W-1:0]     ofs;
  logic                 pio_req, sio_req;
  logic [NUM_MEM-1:0]   hi_q, lo_q;
  logic                 pio_q, sio_q, run_q;

  glue_bank_dec #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB)) u_dec (
    .addr_i(addr_i), .as_n(as_n), .fc(fc), .bank_hit(bank_hit), .iack(iack)
  );

  glue_lane_sel #(.RO_MASK(READ_ONLY_MASK)) u_lane (
    .mem_hit(bank_hit[NUM_MEM-1:0]), .uds_n(uds_n), .lds_n(lds_n), .rw(rw),
    .hi_req(hi_req), .lo_req(lo_req)
  );

  glue_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .io_hit(bank_hit[BANK_IO]),
    .iack(iack), .dtack_n(dtack_n), .vpa_n(vpa_n)
  );

  assign ofs     = addr_i[BANK_LSB-1:1];
  assign pio_req = bank_hit[BANK_IO] && !uds_n && (int'(ofs) < PIO_REGS);
  assign sio_req = bank_hit[BANK_IO] && !lds_n && (int'(ofs) < SIO_REGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      pio_q <= 1'b0;
      sio_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      hi_q  <= hi_req;
      lo_q  <= lo_req;
      pio_q <= pio_req;
      sio_q <= sio_req;
      run_q <= 1'b1;
    end
  end

  assign rom_hi_cs_n  = !hi_q[BANK_ROM];
  assign rom_lo_cs_n  = !lo_q[BANK_ROM];
  assign ram1_hi_cs_n = !hi_q[BANK_RAM1];
  assign ram1_lo_cs_n = !lo_q[BANK_RAM1];
  assign ram2_hi_cs_n = !hi_q[BANK_RAM2];
  assign ram2_lo_cs_n = !lo_q[BANK_RAM2];
  assign pio_cs_n     = !pio_q;
  assign sio_cs_n     = !sio_q;

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(as_n)) |-> (hi_q == '0 && lo_q == '0 && pio_cs_n && sio_cs_n
                                && dtack_n && vpa_n));

  a_r4_rom_read: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !(rom_hi_cs_n && rom_lo_cs_n)) |-> $past(rw));

  a_r6_pio_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !pio_cs_n) |-> (!$past(uds_n) && !vpa_n));

  a_r8_iack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(!as_n && fc[1] && fc[0])) |-> (hi_q == '0 && lo_q == '0
                                                   && pio_cs_n && sio_cs_n));
endmodule

// File: tb/sim_bus_glue_decoder.sv
module sim_bus_glue_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:1] a = '0;
  logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
  logic [2:0]  fc = 3'b001;
  logic rom_hi, rom_lo, r1_hi, r1_lo, r2_hi, r2_lo, pio, sio, dtack, vpa;
  int checks = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_glue_decoder u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(a), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rw(rw), .fc(fc),
    .rom_hi_cs_n(rom_hi), .rom_lo_cs_n(rom_lo), .ram1_hi_cs_n(r1_hi),
    .ram1_lo_cs_n(r1_lo), .ram2_hi_cs_n(r2_hi), .ram2_lo_cs_n(r2_lo),
    .pio_cs_n(pio), .sio_cs_n(sio), .dtack_n(dtack), .vpa_n(vpa)
  );

  function automatic logic [9:0] model();
    logic acc, ia, mem, io;
    int bank, ofs;
    acc  = !as_n;
    ia   = acc && fc[1] && fc[0];
    mem  = acc && !ia;
    bank = int'(a[17:16]);
    ofs  = int'(a[15:1]);
    io   = mem && bank == 3;
    return {
      !(mem && bank == 0 && rw && !uds_n), !(mem && bank == 0 && rw && !lds_n),
      !(mem && bank == 1 && !uds_n),       !(mem && bank == 1 && !lds_n),
      !(mem && bank == 2 && !uds_n),       !(mem && bank == 2 && !lds_n),
      !(io && !uds_n && ofs < 16),         !(io && !lds_n && ofs < 2),
      !(acc && !(ia || io)),               !(acc && (ia || io))};
  endfunction

  function automatic logic [9:0] outs();
    return {rom_hi, rom_lo, r1_hi, r1_lo, r2_hi, r2_lo, pio, sio, dtack, vpa};
  endfunction

  task automatic drive(input logic [23:1] na, input logic nas, input logic nu,
                       input logic nl, input logic nrw, input logic [2:0] nfc);
    a = na; as_n = nas; uds_n = nu; lds_n = nl; rw = nrw; fc = nfc;
  endtask

  // wait one cycle, then compare outputs with the decode of the held inputs
  task automatic check(input string tag);
    logic [9:0] exp;
    exp = model();
    @(negedge clk);
    checks++;
    if (outs() !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b", tag, outs(), exp);
    end
    if (!dtack && !vpa) begin
      bad++;
      $display("FAIL R9: dtack and vpa both low got=%b exp=not-both-low",
               {dtack, vpa});
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    drive(23'h01_0000 >> 0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b101);
    repeat (3) @(negedge clk);
    checks++;
    if (outs() !== 10'h3FF) begin
      bad++;
      $display("FAIL R1: got=%b exp=%b", outs(), 10'h3FF);
    end
    rst_n = 1'b1;
    drive('0, 1'b1, 1'b1, 1'b1, 1'b1, 3'b101);
    check("R10 idle after reset");

    // R2 bank decode, R3 lanes, R4 ROM read only, R5 SRAM both directions
    for (int bk = 0; bk < 4; bk++) begin
      for (int st = 0; st < 3; st++) begin
        for (int d = 0; d < 2; d++) begin
          logic [23:1] wa;
          wa = '0;
          wa[17:16] = 2'(bk);
          wa[5:1] = 5'(bk + st);
          drive(wa, 1'b0, st == 1, st == 2, d[0], 3'b101);
          check(bk == 0 ? "R4 ROM access" : (bk == 3 ? "R8 io bank" : "R5 SRAM access"));
        end
      end
    end
    drive(23'h00_0000, 1'b0, 1'b0, 1'b1, 1'b1, 3'b110);
    check("R3 upper lane only");
    drive(23'h00_0001, 1'b0, 1'b1, 1'b0, 1'b1, 3'b110);
    check("R3 lower lane only");
    drive(23'h00_0004, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101);
    check("R4 ROM write no select");

    // R2 mirror: upper bits set
    drive({6'b101101, 2'd1, 15'h0123}, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001);
    check("R2 mirror ram1");
    drive({6'b111111, 2'd0, 15'h0000}, 1'b0, 1'b0, 1'b0, 1'b1, 3'b110);
    check("R2 mirror rom");

    // R6 / R7 window edges
    drive({6'd0, 2'd3, 15'd15}, 1'b0, 1'b0, 1'b1, 1'b1, 3'b101);
    check("R6 last pio word");
    drive({6'd0, 2'd3, 15'd16}, 1'b0, 1'b0, 1'b1, 1'b1, 3'b101);
    check("R6 past pio window");
    drive({6'd0, 2'd3, 15'd1}, 1'b0, 1'b1, 1'b0, 1'b0, 3'b101);
    check("R7 last sio word");
    drive({6'd0, 2'd3, 15'd2}, 1'b0, 1'b1, 1'b0, 1'b0, 3'b101);
    check("R7 past sio window");
    drive({6'd0, 2'd3, 15'd0}, 1'b0, 1'b1, 1'b0, 1'b1, 3'b101);
    check("R7 sio only on lower lane");

    // R8 interrupt acknowledge, fc2 ignored
    drive({6'd0, 2'd1, 15'h7FF3}, 1'b0, 1'b1, 1'b0, 1'b1, 3'b111);
    check("R8 iack fc=111");
    drive({6'd0, 2'd0, 15'h0003}, 1'b0, 1'b1, 1'b0, 1'b1, 3'b011);
    check("R8 iack fc=011");
    drive({6'd0, 2'd2, 15'h0003}, 1'b0, 1'b0, 1'b0, 1'b1, 3'b110);
    check("R9 fc=110 is memory");

    // R10: strobe high over every bank
    for (int bk = 0; bk < 4; bk++) begin
      drive({6'd0, 2'(bk), 15'd0}, 1'b1, 1'b0, 1'b0, 1'b1, 3'b111);
      check("R10 as_n high");
    end

    // R11: one-cycle latency, output must still show previous decode mid-cycle
    drive({6'd0, 2'd1, 15'd0}, 1'b0, 1'b0, 1'b0, 1'b1, 3'b101);
    check("R11 settle");
    drive({6'd0, 2'd2, 15'd0}, 1'b0, 1'b0, 1'b0, 1'b1, 3'b101);
    #1;
    checks++;
    if (r1_hi !== 1'b0 || r2_hi !== 1'b1) begin
      bad++;
      $display("FAIL R11: got=%b%b exp=01", r1_hi, r2_hi);
    end
    check("R11 next edge");

    // random cycles compared every clock (R2 R3 R9)
    for (int i = 0; i < 400; i++) begin
      logic [23:1] ra;
      ra = 23'($urandom);
      if (i % 3 == 0) ra[15:5] = '0;
      drive(ra, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            3'($urandom));
      check("R2 R3 R9 random");
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule